// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block governs low-power operation of a small processor core. Software writes an 8-bit control register that holds a sleep-enable flag and a 3-bit mode code. When the core reports a sleep instruction while the flag is set and the code names a real mode, the controller enters that mode. It then lowers the matching per-domain clock enables for the CPU, I/O, ADC and asynchronous timer clocks, and the main oscillator enable.

An enabled interrupt wakes the block. It first waits a start-up delay that depends on the mode, because modes that stop the oscillator need a longer settling time. It then holds the core for four more cycles. On the last of those cycles it pulses a dispatch strobe, so the core can enter the interrupt routine and afterwards continue after the sleep instruction. A reset returns everything to the running state, and the core then restarts from its reset vector. A halt output stays high for the whole sleep-to-resume span, so the core can stall its fetch.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: The control register keeps the sleep-enable flag in bit 0 and the mode code in bits 3..1. A write lands on the next clock, and reset clears the whole register to 0x00.
- R2: Register bits 7..4 always read as zero. Writing ones to them changes nothing.
- R3: A sleep request made while the enable flag is 0 has no effect: core_halt stays low and all five enables stay high.
- R4: A sleep request with the flag set and a valid code raises core_halt and applies the mode's gating on the clock after the request. The mode used is the register content held before any write in that same cycle.
- R5: The mode codes 100, 101 and 111 are reserved. A request with one of them is a no-op, and the core keeps running.
- R6: While asleep, the enables {osc, async, adc, io, cpu} are as follows. Idle (000) gives 11110. ADC quiet (001) gives 11100. Power-down (010) gives 00000. Power-save (011) gives 01000. Standby (110) gives 10000.
- R7: If irq_wake is sampled high while asleep, core_halt falls exactly D+4 clocks later. D is SLOW_WAKE for codes 010 and 011 and FAST_WAKE for the other modes. irq_dispatch pulses for one cycle, on the last cycle that core_halt is high.
- R8: During the start-up delay the oscillator enable is on and the other enables keep their sleep values. During the four-cycle halt all enables are on.
- R9: Reset during sleep at once drops core_halt, turns all enables on and clears the register. No irq_dispatch follows.
- R10: irq_wake while the core is running has no effect: no halt and no dispatch pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| sleep_req | input | 1 | Core executes a sleep instruction (one-cycle pulse) |
| irq_wake | input | 1 | An enabled interrupt is pending |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| clk_en_async | output | 1 | Asynchronous timer clock enable |
| osc_en | output | 1 | Main oscillator enable |
| core_halt | output | 1 | Core stall, from sleep entry to the end of the post-wake halt |
| irq_dispatch | output | 1 | One-cycle strobe: the interrupt routine may start |

## Verification
A register write and a sleep request can land in the same cycle. The bench provokes this in two steps. It first loads the power-down code. It then writes the ADC quiet code in the very cycle of the sleep request, and it expects the all-off power-down gating, followed by a readback of the new value. The second collision is a wake interrupt that is already high when sleep is entered. That case is judged by the exact cycle on which core_halt falls and irq_dispatch pulses.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

  localparam int MODE_W = 3;
  localparam int DOM_N  = 5;  // domain bit order: 0 cpu, 1 io, 2 adc, 3 async, 4 osc

  localparam logic [MODE_W-1:0] MD_IDLE  = 3'b000;
  localparam logic [MODE_W-1:0] MD_QUIET = 3'b001;
  localparam logic [MODE_W-1:0] MD_DEEP  = 3'b010;
  localparam logic [MODE_W-1:0] MD_KEEPT = 3'b011;
  localparam logic [MODE_W-1:0] MD_STBY  = 3'b110;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WARM  = 2'd2,
    ST_HALT  = 2'd3
  } seq_state_e;

  function automatic logic mode_ok(input logic [MODE_W-1:0] m);
    return (m == MD_IDLE) || (m == MD_QUIET) || (m == MD_DEEP) ||
           (m == MD_KEEPT) || (m == MD_STBY);
  endfunction

  function automatic logic [DOM_N-1:0] mode_live_mask(input logic [MODE_W-1:0] m);
    logic [DOM_N-1:0] r;
    case (m)
      MD_IDLE:  r = 5'b11110;
      MD_QUIET: r = 5'b11100;
      MD_DEEP:  r = 5'b00000;
      MD_KEEPT: r = 5'b01000;
      MD_STBY:  r = 5'b10000;
      default:  r = 5'b11111;
    endcase
    return r;
  endfunction

  function automatic logic mode_slow(input logic [MODE_W-1:0] m);
    return (m == MD_DEEP) || (m == MD_KEEPT);
  endfunction

endpackage

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg
  import pwr_sleep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              sleep_en,
  output logic [MODE_W-1:0] mode_sel
);

  localparam int LIVE_W = MODE_W + 1;

  logic [LIVE_W-1:0] live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= '0;
    else if (we) live_q <= wdata[LIVE_W-1:0];
  end

  assign rdata    = {{(8-LIVE_W){1'b0}}, live_q};
  assign sleep_en = live_q[0];
  assign mode_sel = live_q[LIVE_W-1:1];

  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[3:0] == $past(wdata[3:0])));

  a_r2_upper_static: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[7:4] == 4'h0));

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_sleep_pkg::*;
#(
  parameter int FAST_WAKE = 0,
  parameter int SLOW_WAKE = 16,
  parameter int HALT_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              irq_wake,
  input  logic              sleep_en,
  input  logic [MODE_W-1:0] mode_sel,
  output seq_state_e        state,
  output logic [MODE_W-1:0] mode_q,
  output logic              core_halt,
  output logic              irq_dispatch
);

  localparam int MAXC  = (SLOW_WAKE > HALT_CYC) ? SLOW_WAKE : HALT_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] FAST_M1 = CNT_W'((FAST_WAKE > 0) ? FAST_WAKE - 1 : 0);
  localparam logic [CNT_W-1:0] SLOW_M1 = CNT_W'((SLOW_WAKE > 0) ? SLOW_WAKE - 1 : 0);
  localparam logic [CNT_W-1:0] HALT_M1 = CNT_W'(HALT_CYC - 1);

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;

  logic enter_evt, wake_evt, in_halt, in_warm, cnt_done, slow_sel, dly_zero;
  logic [CNT_W-1:0] dly_load;

  assign enter_evt = (st_q == ST_RUN) && sleep_req && sleep_en && mode_ok(mode_sel);
  assign wake_evt  = (st_q == ST_SLEEP) && irq_wake;
  assign in_halt   = (st_q == ST_HALT);
  assign in_warm   = (st_q == ST_WARM);
  assign cnt_done  = (cnt_q == '0);
  assign slow_sel  = mode_slow(mode_q);
  assign dly_zero  = slow_sel ? (SLOW_WAKE == 0) : (FAST_WAKE == 0);
  assign dly_load  = slow_sel ? SLOW_M1 : FAST_M1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      mode_q <= MD_IDLE;
    end else begin
      case (st_q)
        ST_RUN: if (enter_evt) begin
          st_q   <= ST_SLEEP;
          mode_q <= mode_sel;
        end
        ST_SLEEP: if (wake_evt) begin
          if (dly_zero) begin
            st_q  <= ST_HALT;
            cnt_q <= HALT_M1;
          end else begin
            st_q  <= ST_WARM;
            cnt_q <= dly_load;
          end
        end
        ST_WARM: if (cnt_done) begin
          st_q  <= ST_HALT;
          cnt_q <= HALT_M1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: if (cnt_done) st_q <= ST_RUN;
                 else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  assign state        = st_q;
  assign core_halt    = (st_q != ST_RUN);
  assign irq_dispatch = in_halt && cnt_done;

  // checker-side run length of the halt phase
  logic [CNT_W-1:0] halt_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_run <= '0;
    else if (in_halt) halt_run <= halt_run + 1'b1;
    else halt_run <= '0;
  end

  a_r3_no_enable_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && sleep_req && !sleep_en) |=> !core_halt);

  a_r5_reserved_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && sleep_req && !mode_ok(mode_sel)) |=> !core_halt);

  a_r4_entry_halts: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt |=> (core_halt && !irq_dispatch));

  a_r7_halt_span: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dispatch |-> (halt_run == HALT_M1));

  a_r7_release_after_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dispatch |=> !core_halt);

  a_r10_running_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && !sleep_req) |=> (!core_halt && !irq_dispatch));

  a_r7_warm_leads_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (in_warm && cnt_done) |=> in_halt);

endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pwr_sleep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  logic [MODE_W-1:0] mode_q,
  output logic [DOM_N-1:0]  dom_en
);

  localparam int OSC_BIT = DOM_N - 1;

  logic [DOM_N-1:0] sleep_mask;
  assign sleep_mask = mode_live_mask(mode_q);

  always_comb begin
    case (state)
      ST_SLEEP: dom_en = sleep_mask;
      ST_WARM: begin
        dom_en          = sleep_mask;
        dom_en[OSC_BIT] = 1'b1;
      end
      default:  dom_en = '1;
    endcase
  end

  a_r6_cpu_off_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP) |-> !dom_en[0]);

  a_r8_osc_on_warm: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WARM) |-> dom_en[OSC_BIT]);

  a_r8_all_on_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |-> (dom_en == '1));

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_sleep_pkg::*;
#(
  parameter int FAST_WAKE = 0,
  parameter int SLOW_WAKE = 16,
  parameter int HALT_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       sleep_req,
  input  logic       irq_wake,
  output logic       clk_en_cpu,
  output logic       clk_en_io,
  output logic       clk_en_adc,
  output logic       clk_en_async,
  output logic       osc_en,
  output logic       core_halt,
  output logic       irq_dispatch
);

  logic              sleep_en;
  logic [MODE_W-1:0] mode_sel, mode_q;
  seq_state_e        state;
  logic [DOM_N-1:0]  dom_en;

  pwr_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .sleep_en(sleep_en), .mode_sel(mode_sel)
  );

  pwr_seq_fsm #(
    .FAST_WAKE(FAST_WAKE), .SLOW_WAKE(SLOW_WAKE), .HALT_CYC(HALT_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .irq_wake(irq_wake),
    .sleep_en(sleep_en), .mode_sel(mode_sel), .state(state), .mode_q(mode_q),
    .core_halt(core_halt), .irq_dispatch(irq_dispatch)
  );

  pwr_clk_gate u_gate (
    .clk(clk), .rst_n(rst_n), .state(state), .mode_q(mode_q), .dom_en(dom_en)
  );

  assign clk_en_cpu   = dom_en[0];
  assign clk_en_io    = dom_en[1];
  assign clk_en_adc   = dom_en[2];
  assign clk_en_async = dom_en[3];
  assign osc_en       = dom_en[4];

  a_r9_running_cpu_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !core_halt |-> (clk_en_cpu && osc_en));

endmodule

// File: tb/test_pwr_sleep_ctrl.sv
module test_pwr_sleep_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int FAST_D = 0;
  localparam int SLOW_D = 16;
  localparam int HALT_N = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, sleep_req = 1'b0, irq_wake = 1'b0;
  logic [7:0] cfg_wdata = 8'h00, cfg_rdata;
  logic clk_en_cpu, clk_en_io, clk_en_adc, clk_en_async, osc_en, core_halt, irq_dispatch;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_sleep_ctrl #(.FAST_WAKE(FAST_D), .SLOW_WAKE(SLOW_D), .HALT_CYC(HALT_N)) i_pwr_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sleep_req(sleep_req), .irq_wake(irq_wake), .clk_en_cpu(clk_en_cpu), .clk_en_io(clk_en_io),
    .clk_en_adc(clk_en_adc), .clk_en_async(clk_en_async), .osc_en(osc_en),
    .core_halt(core_halt), .irq_dispatch(irq_dispatch)
  );

  function automatic logic [4:0] en_now();
    return {osc_en, clk_en_async, clk_en_adc, clk_en_io, clk_en_cpu};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // vector: {wdata[7:0], sleeps, slow, mask[4:0]}, mask order {osc,async,adc,io,cpu}
  localparam int NV = 9;
  localparam logic [14:0] VEC [NV] = '{
    {8'h01, 1'b1, 1'b0, 5'b11110},  // idle
    {8'h03, 1'b1, 1'b0, 5'b11100},  // adc quiet
    {8'h05, 1'b1, 1'b1, 5'b00000},  // power-down
    {8'h07, 1'b1, 1'b1, 5'b01000},  // power-save
    {8'h09, 1'b0, 1'b0, 5'b11111},  // 100 reserved
    {8'h0B, 1'b0, 1'b0, 5'b11111},  // 101 reserved
    {8'h0D, 1'b1, 1'b0, 5'b10000},  // standby
    {8'h0F, 1'b0, 1'b0, 5'b11111},  // 111 reserved
    {8'h04, 1'b0, 1'b1, 5'b11111}   // enable clear
  };

  task automatic wr(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wake_and_time(input int d, input logic [4:0] mask);
    int n;
    bit seen;
    n = 0; seen = 1'b0;
    irq_wake = 1'b1;
    while (core_halt && n < 200) begin
      @(negedge clk);
      n++;
      if (n == 1 && d > 0)
        check(en_now() == (mask | 5'b10000), "R8 warm enables", en_now(), mask | 5'b10000);
      if (n == d + 1)
        check(en_now() == 5'b11111, "R8 halt enables", en_now(), 5'b11111);
      if (irq_dispatch) begin
        check(n == d + HALT_N, "R7 dispatch cycle", n, d + HALT_N);
        seen = 1'b1;
      end
    end
    irq_wake = 1'b0;
    check(n == d + HALT_N + 1, "R7 halt release", n, d + HALT_N + 1);
    check(seen, "R7 dispatch seen", seen, 1);
  endtask

  initial begin : wd
    #(CLK_PERIOD * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    check(cfg_rdata == 8'h00, "R1 reset reg", cfg_rdata, 0);
    check(!core_halt && en_now() == 5'b11111, "R1 reset outputs", en_now(), 5'h1f);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [7:0] w; logic sl, slw; logic [4:0] m;
      {w, sl, slw, m} = VEC[i];
      wr(w);
      check(cfg_rdata == w, "R1 readback", cfg_rdata, w);
      @(negedge clk); sleep_req = 1'b1;
      @(negedge clk); sleep_req = 1'b0;
      if (sl) begin
        check(core_halt == 1'b1, "R4 halt on entry", core_halt, 1);
        check(en_now() == m, "R6 sleep enables", en_now(), m);
        @(negedge clk);
        check(core_halt == 1'b1, "R4 stays asleep", core_halt, 1);
        wake_and_time(slw ? SLOW_D : FAST_D, m);
      end else begin
        check(!core_halt && en_now() == 5'b11111,
              (w[0] ? "R5 reserved noop" : "R3 no enable noop"), en_now(), 5'h1f);
      end
    end

    // R2: upper bits ignored
    wr(8'hF3);
    check(cfg_rdata == 8'h03, "R2 upper bits", cfg_rdata, 8'h03);

    // R10: interrupt while running
    @(negedge clk); irq_wake = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(!core_halt && !irq_dispatch, "R10 irq while running", core_halt, 0);
    end
    irq_wake = 1'b0;

    // R4: write and sleep in one cycle, old content decides the mode
    wr(8'h05);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 8'h03; sleep_req = 1'b1;
    @(negedge clk); cfg_we = 1'b0; sleep_req = 1'b0;
    check(en_now() == 5'b00000, "R4 old mode used", en_now(), 0);
    check(cfg_rdata == 8'h03, "R4 write kept", cfg_rdata, 3);
    // irq already pending at next entry handled by wake timing
    wake_and_time(SLOW_D, 5'b00000);

    // R7: irq high at the moment sleep is entered (idle, fast)
    wr(8'h01);
    @(negedge clk); sleep_req = 1'b1; irq_wake = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    check(core_halt, "R7 entry with pending irq", core_halt, 1);
    wake_and_time(FAST_D, 5'b11110);

    // R9: reset during power-down sleep
    wr(8'h05);
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    check(core_halt, "R9 asleep before reset", core_halt, 1);
    rst_n = 1'b0;
    #1;
    check(!core_halt && en_now() == 5'b11111, "R9 reset wakes", en_now(), 5'h1f);
    check(cfg_rdata == 8'h00, "R9 reset clears reg", cfg_rdata, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (6) begin
      @(negedge clk);
      check(!irq_dispatch && !core_halt, "R9 no dispatch after reset", irq_dispatch, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule